// File: doc/BRIEF.md
# Queue Pair Lifecycle Manager

This block keeps the bookkeeping of which submission queues (SQs) and completion queues (CQs) currently exist in a storage controller, and it judges every queue create or delete request against the ordering rules between the two kinds of queue. A CQ has to exist before any SQ can be bound to it. A CQ cannot be removed while an SQ still points at it. Identifier 0 always belongs to the admin pair, so software can never create or remove it.

Requests arrive one at a time through a valid/ready handshake. The cycle after a request is accepted, the block raises a response strobe for one cycle with a 3-bit status. While that response is presented, the block holds ready low. A successful request updates the queue tables at the same edge that accepts it. A failed request leaves all state untouched.

The block also checks command class against the queue the command arrived on. Queue-management commands are legal only on queue 0. An I/O command is legal only on an existing I/O SQ. The width of the queue identifier is a parameter and may be up to 16 bits.

Top module: `qp_lifecycle_mgr`

## Requirements
- R1: After a synchronous reset, only the admin pair (identifier 0) exists. Every I/O SQ and CQ is absent: an I/O command on any nonzero queue returns status 5, and deleting any nonzero CQ or SQ returns status 5.
- R2: A create or delete request (opcodes 1 to 4) that arrives on queue 0 and names target identifier 0 returns status 1 and changes nothing.
- R3: Create-SQ (opcode 2) returns status 2 and creates nothing if its bound CQ (the req_cqid field) is 0 or does not exist.
- R4: Delete-CQ (opcode 4) returns status 3 and keeps the CQ while at least one SQ is bound to it.
- R5: Creating an identifier that already exists returns status 4, and deleting one that does not exist returns status 5. Neither changes any state, including bound-SQ counts.
- R6: Each CQ keeps a count of the SQs bound to it. A successful create-SQ raises the count by one and a successful delete-SQ lowers it by one. Delete-CQ succeeds only once the count is back to zero.
- R7: Status 6 is returned in three cases: an opcode above 4; an I/O command (opcode 0) arriving on queue 0; a management opcode (1 to 4) arriving on a nonzero queue. Status 6 takes priority over every other status.
- R8: An I/O command (opcode 0) arriving on an existing I/O SQ returns status 0.
- R9: A request is accepted when req_valid and req_ready are both high at a clock edge. rsp_valid is high for exactly the next cycle, and req_ready is low during that cycle. No response is produced without an acceptance.
- R10: Successful create-CQ (1), create-SQ (2), delete-SQ (3) and delete-CQ (4) requests return status 0 for any nonzero identifier, including the largest one. Their effect is visible to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Opcode: 0 I/O, 1 create CQ, 2 create SQ, 3 delete SQ, 4 delete CQ |
| req_src_qid | input | QID_W | Queue the command arrived on |
| req_qid | input | QID_W | Target queue identifier |
| req_cqid | input | QID_W | CQ to bind, used by create SQ |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 3 | 0 ok, 1 reserved id, 2 CQ missing, 3 CQ in use, 4 exists, 5 absent, 6 bad opcode |

## Verification
The bench targets three kinds of fault:
- Counting faults. Two SQs are bound to one CQ and then removed one at a time. A design without a true count would free the CQ after the first SQ delete. A design that lets a duplicate create bump the count would never free the CQ at all.
- Ordering faults. An SQ is created against a missing CQ and against CQ 0. A design that skipped the ordering check would report success, and a later I/O command on that SQ would also succeed.
- Priority and handshake faults. A management request is sent from an I/O queue with target 0, where a wrong priority would return status 1 instead of 6. A request is held across the busy cycle, where a design that ignored ready would produce a second response.

// File: rtl/qp_pkg.sv
package qp_pkg;

    typedef enum logic [2:0] {
        OP_IO    = 3'd0,
        OP_MK_CQ = 3'd1,
        OP_MK_SQ = 3'd2,
        OP_RM_SQ = 3'd3,
        OP_RM_CQ = 3'd4
    } qp_op_e;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_RSVD    = 3'd1,
        ST_NO_CQ   = 3'd2,
        ST_CQ_BUSY = 3'd3,
        ST_EXISTS  = 3'd4,
        ST_ABSENT  = 3'd5,
        ST_BAD_OP  = 3'd6
    } qp_status_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_MK_CQ,
        ACT_MK_SQ,
        ACT_RM_SQ,
        ACT_RM_CQ
    } qp_act_e;

endpackage

// File: rtl/qp_check.sv
module qp_check
    import qp_pkg::*;
#(
    parameter int QID_W = 4
) (
    input  logic [2:0]       op_i,
    input  logic [QID_W-1:0] src_i,
    input  logic [QID_W-1:0] qid_i,
    input  logic [QID_W-1:0] cqid_i,
    input  logic             src_sq_vld_i,
    input  logic             tgt_sq_vld_i,
    input  logic             tgt_cq_vld_i,
    input  logic             bind_cq_vld_i,
    input  logic             tgt_cq_busy_i,
    output qp_status_e       status_o,
    output qp_act_e          act_o
);
    // Priority: opcode class, reserved id, existence, ordering.
    always_comb begin
        status_o = ST_OK;
        act_o    = ACT_NONE;
        if (op_i > 3'd4) begin
            status_o = ST_BAD_OP;
        end else if (op_i == OP_IO) begin
            if (src_i == '0) begin
                status_o = ST_BAD_OP;
            end else if (!src_sq_vld_i) begin
                status_o = ST_ABSENT;
            end
        end else if (src_i != '0) begin
            status_o = ST_BAD_OP;
        end else if (qid_i == '0) begin
            status_o = ST_RSVD;
        end else begin
            case (op_i)
                OP_MK_CQ: begin
                    if (tgt_cq_vld_i) status_o = ST_EXISTS;
                    else              act_o    = ACT_MK_CQ;
                end
                OP_MK_SQ: begin
                    if (tgt_sq_vld_i)                          status_o = ST_EXISTS;
                    else if (cqid_i == '0 || !bind_cq_vld_i)   status_o = ST_NO_CQ;
                    else                                       act_o    = ACT_MK_SQ;
                end
                OP_RM_SQ: begin
                    if (!tgt_sq_vld_i) status_o = ST_ABSENT;
                    else               act_o    = ACT_RM_SQ;
                end
                OP_RM_CQ: begin
                    if (!tgt_cq_vld_i)     status_o = ST_ABSENT;
                    else if (tgt_cq_busy_i) status_o = ST_CQ_BUSY;
                    else                   act_o    = ACT_RM_CQ;
                end
                default: status_o = ST_BAD_OP;
            endcase
        end
    end

endmodule

// File: rtl/qp_table.sv
module qp_table
    import qp_pkg::*;
#(
    parameter int QID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_i,
    input  qp_act_e          act_i,
    input  logic [QID_W-1:0] src_i,
    input  logic [QID_W-1:0] qid_i,
    input  logic [QID_W-1:0] cqid_i,
    output logic             src_sq_vld_o,
    output logic             tgt_sq_vld_o,
    output logic             tgt_cq_vld_o,
    output logic             bind_cq_vld_o,
    output logic             tgt_cq_busy_o
);
    localparam int NUM_Q = 1 << QID_W;
    localparam int CNT_W = QID_W;   // at most NUM_Q-1 SQs per CQ

    typedef struct packed {
        logic [NUM_Q-1:0]             sq_vld;
        logic [NUM_Q-1:0]             cq_vld;
        logic [NUM_Q-1:0][QID_W-1:0]  sq_cq;
        logic [NUM_Q-1:0][CNT_W-1:0]  cq_cnt;
    } tbl_t;

    localparam tbl_t TBL_RST = '{
        sq_vld: NUM_Q'(1),
        cq_vld: NUM_Q'(1),
        sq_cq:  '0,
        cq_cnt: '0
    };

    tbl_t             tbl_d, tbl_q;
    logic [QID_W-1:0] bound_id;

    assign bound_id      = tbl_q.sq_cq[qid_i];
    assign src_sq_vld_o  = tbl_q.sq_vld[src_i];
    assign tgt_sq_vld_o  = tbl_q.sq_vld[qid_i];
    assign tgt_cq_vld_o  = tbl_q.cq_vld[qid_i];
    assign bind_cq_vld_o = tbl_q.cq_vld[cqid_i];
    assign tgt_cq_busy_o = |tbl_q.cq_cnt[qid_i];

    always_comb begin
        tbl_d = tbl_q;
        if (commit_i) begin
            case (act_i)
                ACT_MK_CQ: tbl_d.cq_vld[qid_i] = 1'b1;
                ACT_MK_SQ: begin
                    tbl_d.sq_vld[qid_i]  = 1'b1;
                    tbl_d.sq_cq[qid_i]   = cqid_i;
                    tbl_d.cq_cnt[cqid_i] = tbl_q.cq_cnt[cqid_i] + CNT_W'(1);
                end
                ACT_RM_SQ: begin
                    tbl_d.sq_vld[qid_i]    = 1'b0;
                    tbl_d.sq_cq[qid_i]     = '0;
                    tbl_d.cq_cnt[bound_id] = tbl_q.cq_cnt[bound_id] - CNT_W'(1);
                end
                ACT_RM_CQ: tbl_d.cq_vld[qid_i] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tbl_q <= TBL_RST;
        else     tbl_q <= tbl_d;
    end

endmodule

// File: rtl/qp_lifecycle_mgr.sv
module qp_lifecycle_mgr
    import qp_pkg::*;
#(
    parameter int QID_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [QID_W-1:0] req_src_qid,
    input  logic [QID_W-1:0] req_qid,
    input  logic [QID_W-1:0] req_cqid,
    output logic             rsp_valid,
    output logic [2:0]       rsp_status
);
    typedef struct packed {
        logic       vld;
        qp_status_e st;
    } rsp_t;

    rsp_t       rsp_d, rsp_q;
    logic       accept;
    qp_status_e chk_status;
    qp_act_e    chk_act;
    logic       src_sq_vld, tgt_sq_vld, tgt_cq_vld, bind_cq_vld, tgt_cq_busy;

    assign req_ready  = ~rsp_q.vld;
    assign accept     = req_valid & req_ready;
    assign rsp_valid  = rsp_q.vld;
    assign rsp_status = rsp_q.st;

    qp_table #(.QID_W(QID_W)) u_table (
        .clk           (clk),
        .rst           (rst),
        .commit_i      (accept),
        .act_i         (chk_act),
        .src_i         (req_src_qid),
        .qid_i         (req_qid),
        .cqid_i        (req_cqid),
        .src_sq_vld_o  (src_sq_vld),
        .tgt_sq_vld_o  (tgt_sq_vld),
        .tgt_cq_vld_o  (tgt_cq_vld),
        .bind_cq_vld_o (bind_cq_vld),
        .tgt_cq_busy_o (tgt_cq_busy)
    );

    qp_check #(.QID_W(QID_W)) u_check (
        .op_i          (req_op),
        .src_i         (req_src_qid),
        .qid_i         (req_qid),
        .cqid_i        (req_cqid),
        .src_sq_vld_i  (src_sq_vld),
        .tgt_sq_vld_i  (tgt_sq_vld),
        .tgt_cq_vld_i  (tgt_cq_vld),
        .bind_cq_vld_i (bind_cq_vld),
        .tgt_cq_busy_i (tgt_cq_busy),
        .status_o      (chk_status),
        .act_o         (chk_act)
    );

    always_comb begin
        rsp_d.vld = accept;
        rsp_d.st  = accept ? chk_status : rsp_q.st;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '{vld: 1'b0, st: ST_OK};
        else     rsp_q <= rsp_d;
    end

endmodule

// File: rtl/qp_lifecycle_mgr_sva.sv
module qp_lifecycle_mgr_sva #(
    parameter int QID_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_op,
    input logic [QID_W-1:0] req_src_qid,
    input logic [QID_W-1:0] req_qid,
    input logic             rsp_valid,
    input logic [2:0]       rsp_status
);
    logic acc, mgmt;
    assign acc  = req_valid && req_ready;
    assign mgmt = (req_op >= 3'd1) && (req_op <= 3'd4);

    assert_rsp_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);
    assert_no_rsp_without_accept_R9: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);
    assert_ready_low_busy_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);
    assert_admin_id_reserved_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && mgmt && req_src_qid == '0 && req_qid == '0) |=> rsp_status == 3'd1);
    assert_undef_op_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op > 3'd4) |=> rsp_status == 3'd6);
    assert_io_on_admin_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd0 && req_src_qid == '0) |=> rsp_status == 3'd6);
    assert_mgmt_on_io_queue_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && mgmt && req_src_qid != '0) |=> rsp_status == 3'd6);

endmodule

bind qp_lifecycle_mgr qp_lifecycle_mgr_sva #(.QID_W(QID_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_src_qid (req_src_qid),
    .req_qid     (req_qid),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status)
);

// File: tb/tb_qp_lifecycle_mgr.sv
module tb_qp_lifecycle_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 4;
    localparam int MAXQ = (1 << QW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [QW-1:0] req_src_qid = '0;
    logic [QW-1:0] req_qid = '0;
    logic [QW-1:0] req_cqid = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_status;

    int checks = 0;
    int failures = 0;

    qp_lifecycle_mgr #(.QID_W(QW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_src_qid(req_src_qid), .req_qid(req_qid),
        .req_cqid(req_cqid), .rsp_valid(rsp_valid), .rsp_status(rsp_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one request; response sampled at the negedge after the accepting edge
    task automatic do_req(input int op, input int src, input int qid, input int cq,
                          input int exp, input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_op      = 3'(op);
        req_src_qid = QW'(src);
        req_qid     = QW'(qid);
        req_cqid    = QW'(cq);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_status === 3'(exp), req,
              rsp_valid ? int'(rsp_status) : -1, exp);
    endtask

    task automatic t_reset();
        check(rsp_valid === 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        check(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);
        do_req(0, 1, 0, 0, 5, "R1 io on absent sq1");
        do_req(4, 0, 1, 0, 5, "R1 delete absent cq1");
        do_req(3, 0, MAXQ, 0, 5, "R1 delete absent sq max");
    endtask

    task automatic t_admin_reserved();
        do_req(1, 0, 0, 0, 1, "R2 create cq0");
        do_req(2, 0, 0, 1, 1, "R2 create sq0");
        do_req(3, 0, 0, 0, 1, "R2 delete sq0");
        do_req(4, 0, 0, 0, 1, "R2 delete cq0");
    endtask

    task automatic t_create_order();
        do_req(2, 0, 2, 3, 2, "R3 sq2 on missing cq3");
        do_req(0, 2, 0, 0, 5, "R3 sq2 not created");
        do_req(2, 0, 2, 0, 2, "R3 sq2 on cq0");
        do_req(1, 0, 3, 0, 0, "R10 create cq3");
        do_req(2, 0, 2, 3, 0, "R10 create sq2 on cq3");
        do_req(0, 2, 0, 0, 0, "R8 io on sq2");
    endtask

    task automatic t_refcount();
        do_req(2, 0, 4, 3, 0, "R6 create sq4 on cq3");
        do_req(4, 0, 3, 0, 3, "R4 delete busy cq3");
        do_req(3, 0, 2, 0, 0, "R6 delete sq2");
        do_req(4, 0, 3, 0, 3, "R6 cq3 still bound by sq4");
        do_req(0, 4, 0, 0, 0, "R8 io on sq4");
        do_req(3, 0, 4, 0, 0, "R6 delete sq4");
        do_req(4, 0, 3, 0, 0, "R6 delete free cq3");
        do_req(0, 4, 0, 0, 5, "R10 io on deleted sq4");
        do_req(2, 0, 5, 3, 2, "R3 sq5 on deleted cq3");
    endtask

    task automatic t_duplicates();
        do_req(1, 0, MAXQ, 0, 0, "R10 create cq max");
        do_req(1, 0, MAXQ, 0, 4, "R5 duplicate cq");
        do_req(2, 0, MAXQ, MAXQ, 0, "R10 create sq max");
        do_req(2, 0, MAXQ, MAXQ, 4, "R5 duplicate sq");
        do_req(4, 0, MAXQ, 0, 3, "R4 cq max busy");
        do_req(3, 0, MAXQ, 0, 0, "R10 delete sq max");
        do_req(4, 0, MAXQ, 0, 0, "R5 count not bumped by duplicate");
        do_req(3, 0, MAXQ, 0, 5, "R5 delete absent sq");
        do_req(4, 0, MAXQ, 0, 5, "R5 delete absent cq");
    endtask

    task automatic t_opclass();
        do_req(1, 1, 6, 0, 6, "R7 mgmt on io queue");
        do_req(1, 0, 6, 0, 0, "R7 bad request made no cq6");
        do_req(5, 0, 1, 0, 6, "R7 opcode 5");
        do_req(6, 0, 1, 0, 6, "R7 opcode 6");
        do_req(7, 2, 1, 0, 6, "R7 opcode 7");
        do_req(1, 3, 0, 0, 6, "R7 priority over reserved id");
        do_req(0, 0, 0, 0, 6, "R7 io on admin queue");
    endtask

    task automatic t_handshake();
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_src_qid = '0; req_qid = QW'(7); req_cqid = '0;
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_status === 3'd0, "R9 held request first rsp",
              int'(rsp_status), 0);
        check(req_ready === 1'b0, "R9 ready low during rsp", int'(req_ready), 0);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 single response per accept", int'(rsp_valid), 0);
        req_valid = 1'b0;
        do_req(1, 0, 7, 0, 4, "R9 cq7 created once");
    endtask

    task automatic t_reset_clears();
        apply_reset();
        do_req(2, 0, 8, 6, 2, "R1 cq6 cleared by reset");
        do_req(4, 0, 7, 0, 5, "R1 cq7 cleared by reset");
        do_req(0, 2, 0, 0, 5, "R1 sq2 absent after reset");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        apply_reset();
        t_reset();
        t_admin_reserved();
        t_create_order();
        t_refcount();
        t_duplicates();
        t_opclass();
        t_handshake();
        t_reset_clears();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule